// File: doc/BRIEF.md
# Register Window Trap Controller

This block holds the window state of an integer core whose registers are organised as a ring of overlapping windows. It keeps the current window index, a mask that marks each window as unusable, and the trap state: supervisor mode, the saved previous supervisor mode, trap enable and the trap base register. The core sends it single-cycle requests to move one window down (save), to move one window up (restore), or to enter a trap.

A save or restore whose target window is marked in the mask does not move the window. It raises an overflow or underflow pulse, and the core turns that pulse into a trap. Trap entry always moves one window down, whatever the mask says. It updates the supervisor and enable bits, records the trap number in the trap base register, and drives a write port that carries two return-link values. The core stores these values in locals 1 and 2 of the new window. The register storage itself lives outside this block. It holds 16 registers per window, 8 globals, and 8 spare entries that cover the wrap from the last window back to the first.

Top module: `regwin_trap_ctrl`

## Requirements
- R1: After reset, cur_win is 0, sup is 1, prev_sup is 0, trap_en is 0, tbr is 0 and every window mask bit is 0. win_ovf, win_unf and link_we are all low.
- R2: A save moves to window (cur_win − 1) mod NWIN, so window 0 goes to NWIN−1. If that window's mask bit is clear, cur_win takes the new value on the next cycle and no pulse is raised.
- R3: A save whose target window has its mask bit set leaves cur_win unchanged. It raises win_ovf for exactly one cycle.
- R4: A restore moves to window (cur_win + 1) mod NWIN, so NWIN−1 goes to 0. If that window's mask bit is clear, cur_win takes the new value on the next cycle and no pulse is raised.
- R5: A restore whose target window has its mask bit set leaves cur_win unchanged. It raises win_unf for exactly one cycle.
- R6: Trap entry sets cur_win to (cur_win − 1) mod NWIN without consulting the mask. It copies the old sup into prev_sup, sets sup to 1 and clears trap_en.
- R7: On trap entry, tbr[XLEN-1:TTW+4] keeps its base value, tbr[TTW+3:4] takes the trap number and tbr[3:0] reads 0.
- R8: Trap entry drives link_we high for one cycle, with link_win equal to the new window. If the top bit of the trap number (bit 7 at TTW=8) is 1, link_ret0 is pc and link_ret1 is npc. Otherwise link_ret0 is pc − 4 and link_ret1 is pc.
- R9: A trap request beats a save or restore in the same cycle, and a save beats a restore.
- R10: wim_we loads the mask, and the new mask is used from the next cycle. ctl_we writes sup and trap_en, but not in a cycle that also enters a trap. base_we loads the tbr base field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| save_req | input | 1 | Move one window down (pulse) |
| restore_req | input | 1 | Move one window up (pulse) |
| trap_req | input | 1 | Enter trap (pulse) |
| trap_type | input | TTW (8) | Trap number |
| pc | input | XLEN (32) | Current program counter |
| npc | input | XLEN (32) | Next program counter |
| wim_we | input | 1 | Load window mask |
| wim_wdata | input | NWIN (32) | New window mask, bit i marks window i |
| ctl_we | input | 1 | Write sup and trap_en |
| ctl_sup | input | 1 | Value for sup |
| ctl_en | input | 1 | Value for trap_en |
| base_we | input | 1 | Load trap base field |
| base_wdata | input | XLEN−TTW−4 (20) | New trap base field |
| cur_win | output | log2 NWIN (5) | Current window index |
| prev_sup | output | 1 | Supervisor mode before last trap |
| sup | output | 1 | Supervisor mode |
| trap_en | output | 1 | Trap enable |
| tbr | output | XLEN (32) | Trap base register |
| win_ovf | output | 1 | Save blocked by mask (pulse) |
| win_unf | output | 1 | Restore blocked by mask (pulse) |
| link_we | output | 1 | Link write strobe |
| link_win | output | log2 NWIN (5) | Window that receives the links |
| link_ret0 | output | XLEN (32) | Value for local 1 |
| link_ret1 | output | XLEN (32) | Value for local 2 |

## Verification
The bench builds the block with NWIN=8, XLEN=32 and TTW=8. With eight windows it can go through every one of the 256 mask patterns from every start window, in both directions. That covers both wraps and every blocked and unblocked move. The 8-bit trap number lets it sweep all 256 trap types, so both link classes get checked, and it mixes in same-cycle save and restore requests to exercise priority.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  typedef enum logic [1:0] {
    WOP_IDLE    = 2'd0,
    WOP_DOWN    = 2'd1,
    WOP_UP      = 2'd2,
    WOP_TRAP    = 2'd3
  } win_op_e;
endpackage

// File: rtl/rwt_window.sv
module rwt_window
  import rwt_pkg::*;
#(
  parameter int NWIN = 32,
  localparam int CW = $clog2(NWIN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  win_op_e         op,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  output logic [CW-1:0]   cur_win,
  output logic [CW-1:0]   down_win,
  output logic            win_ovf,
  output logic            win_unf
);
  logic [NWIN-1:0] mask_q;
  logic [CW-1:0]   up_win;

  always_comb begin
    down_win = (cur_win == '0) ? CW'(NWIN - 1) : cur_win - CW'(1);
    up_win   = (cur_win == CW'(NWIN - 1)) ? '0 : cur_win + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_win <= '0;
      mask_q  <= '0;
      win_ovf <= 1'b0;
      win_unf <= 1'b0;
    end else begin
      win_ovf <= 1'b0;
      win_unf <= 1'b0;
      if (wim_we) mask_q <= wim_wdata;
      case (op)
        WOP_DOWN: if (mask_q[down_win]) win_ovf <= 1'b1;
                  else                  cur_win <= down_win;
        WOP_UP:   if (mask_q[up_win])   win_unf <= 1'b1;
                  else                  cur_win <= up_win;
        WOP_TRAP: cur_win <= down_win;
        default:  ;
      endcase
    end
  end

  // R3
  ovf_holds_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_ovf |-> cur_win == $past(cur_win));
  // R5
  unf_holds_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_unf |-> cur_win == $past(cur_win));
  // R3
  ovf_unf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_ovf && win_unf));
endmodule

// File: rtl/rwt_trap_state.sv
module rwt_trap_state #(
  parameter int XLEN = 32,
  parameter int TTW  = 8,
  localparam int LO  = TTW + 4,
  localparam int BW  = XLEN - LO
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_trap,
  input  logic [TTW-1:0] trap_type,
  input  logic           ctl_we,
  input  logic           ctl_sup,
  input  logic           ctl_en,
  input  logic           base_we,
  input  logic [BW-1:0]  base_wdata,
  output logic           prev_sup,
  output logic           sup,
  output logic           trap_en,
  output logic [XLEN-1:0] tbr
);
  logic [BW-1:0]  base_q;
  logic [TTW-1:0] tt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sup <= 1'b0;
      sup      <= 1'b1;
      trap_en  <= 1'b0;
      base_q   <= '0;
      tt_q     <= '0;
    end else begin
      if (take_trap) begin
        prev_sup <= sup;
        sup      <= 1'b1;
        trap_en  <= 1'b0;
        tt_q     <= trap_type;
      end else if (ctl_we) begin
        sup     <= ctl_sup;
        trap_en <= ctl_en;
      end
      if (base_we) base_q <= base_wdata;
    end
  end

  assign tbr = {base_q, tt_q, 4'b0000};

  // R6
  trap_entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (sup && !trap_en && prev_sup == $past(sup)));
  // R7
  trap_number_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_trap |=> (tbr[LO-1:4] == $past(trap_type) && tbr[3:0] == 4'b0000));
endmodule

// File: rtl/rwt_link.sv
module rwt_link #(
  parameter int XLEN = 32,
  parameter int TTW  = 8,
  parameter int CW   = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_trap,
  input  logic [TTW-1:0]  trap_type,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  input  logic [CW-1:0]   new_win,
  output logic            link_we,
  output logic [CW-1:0]   link_win,
  output logic [XLEN-1:0] link_ret0,
  output logic [XLEN-1:0] link_ret1
);
  logic            resume_class;
  logic [XLEN-1:0] ret0_d, ret1_d;

  always_comb begin
    resume_class = trap_type[TTW-1];
    ret0_d = resume_class ? pc  : pc - XLEN'(4);
    ret1_d = resume_class ? npc : pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_we   <= 1'b0;
      link_win  <= '0;
      link_ret0 <= '0;
      link_ret1 <= '0;
    end else begin
      link_we <= take_trap;
      if (take_trap) begin
        link_win  <= new_win;
        link_ret0 <= ret0_d;
        link_ret1 <= ret1_d;
      end
    end
  end

  // R8
  link_follows_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> $past(take_trap));
endmodule

// File: rtl/regwin_trap_ctrl.sv
module regwin_trap_ctrl
  import rwt_pkg::*;
#(
  parameter int NWIN = 32,
  parameter int XLEN = 32,
  parameter int TTW  = 8,
  localparam int CW  = $clog2(NWIN),
  localparam int BW  = XLEN - TTW - 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_req,
  input  logic [TTW-1:0]  trap_type,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] npc,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  input  logic            ctl_we,
  input  logic            ctl_sup,
  input  logic            ctl_en,
  input  logic            base_we,
  input  logic [BW-1:0]   base_wdata,
  output logic [CW-1:0]   cur_win,
  output logic            prev_sup,
  output logic            sup,
  output logic            trap_en,
  output logic [XLEN-1:0] tbr,
  output logic            win_ovf,
  output logic            win_unf,
  output logic            link_we,
  output logic [CW-1:0]   link_win,
  output logic [XLEN-1:0] link_ret0,
  output logic [XLEN-1:0] link_ret1
);
  win_op_e       op;
  logic [CW-1:0] down_win;

  always_comb begin
    if (trap_req)         op = WOP_TRAP;
    else if (save_req)    op = WOP_DOWN;
    else if (restore_req) op = WOP_UP;
    else                  op = WOP_IDLE;
  end

  rwt_window #(.NWIN(NWIN)) u_win (
    .clk(clk), .rst_n(rst_n), .op(op),
    .wim_we(wim_we), .wim_wdata(wim_wdata),
    .cur_win(cur_win), .down_win(down_win),
    .win_ovf(win_ovf), .win_unf(win_unf)
  );

  rwt_trap_state #(.XLEN(XLEN), .TTW(TTW)) u_state (
    .clk(clk), .rst_n(rst_n), .take_trap(trap_req), .trap_type(trap_type),
    .ctl_we(ctl_we), .ctl_sup(ctl_sup), .ctl_en(ctl_en),
    .base_we(base_we), .base_wdata(base_wdata),
    .prev_sup(prev_sup), .sup(sup), .trap_en(trap_en), .tbr(tbr)
  );

  rwt_link #(.XLEN(XLEN), .TTW(TTW), .CW(CW)) u_link (
    .clk(clk), .rst_n(rst_n), .take_trap(trap_req), .trap_type(trap_type),
    .pc(pc), .npc(npc), .new_win(down_win),
    .link_we(link_we), .link_win(link_win),
    .link_ret0(link_ret0), .link_ret1(link_ret1)
  );

  // R9
  trap_beats_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && (save_req || restore_req)) |=> (!win_ovf && !win_unf && link_we));
endmodule

// File: tb/regwin_trap_ctrl_test.sv
module regwin_trap_ctrl_test;
  localparam int NW = 8, XL = 32, TW = 8, CWB = 3, BWB = XL - TW - 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic save_req = 0, restore_req = 0, trap_req = 0, wim_we = 0, ctl_we = 0;
  logic ctl_sup = 0, ctl_en = 0, base_we = 0;
  logic [TW-1:0]  trap_type = '0;
  logic [XL-1:0]  pc = '0, npc = '0;
  logic [NW-1:0]  wim_wdata = '0;
  logic [BWB-1:0] base_wdata = '0;
  logic [CWB-1:0] cur_win, link_win;
  logic prev_sup, sup, trap_en, win_ovf, win_unf, link_we;
  logic [XL-1:0] tbr, link_ret0, link_ret1;

  always #10 clk = ~clk;

  regwin_trap_ctrl #(.NWIN(NW), .XLEN(XL), .TTW(TW)) uut (
    .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
    .trap_req(trap_req), .trap_type(trap_type), .pc(pc), .npc(npc),
    .wim_we(wim_we), .wim_wdata(wim_wdata), .ctl_we(ctl_we), .ctl_sup(ctl_sup),
    .ctl_en(ctl_en), .base_we(base_we), .base_wdata(base_wdata),
    .cur_win(cur_win), .prev_sup(prev_sup), .sup(sup), .trap_en(trap_en),
    .tbr(tbr), .win_ovf(win_ovf), .win_unf(win_unf), .link_we(link_we),
    .link_win(link_win), .link_ret0(link_ret0), .link_ret1(link_ret1)
  );

  int n_chk = 0, n_bad = 0;
  int exp_win = 0;
  bit done = 0;

  function automatic int wdn(int c); return (c + NW - 1) % NW; endfunction
  function automatic int wup(int c); return (c + 1) % NW; endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fire();
    @(negedge clk);
    save_req = 0; restore_req = 0; trap_req = 0;
    wim_we = 0; ctl_we = 0; base_we = 0;
  endtask

  task automatic load_mask(input logic [NW-1:0] m);
    @(negedge clk); wim_we = 1; wim_wdata = m; fire();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cur_win == 0, "R1 cur_win", 64'(cur_win), 0);
    chk(sup == 1, "R1 sup", 64'(sup), 1);
    chk(prev_sup == 0, "R1 prev_sup", 64'(prev_sup), 0);
    chk(trap_en == 0, "R1 trap_en", 64'(trap_en), 0);
    chk(tbr == 0, "R1 tbr", 64'(tbr), 0);
    chk(!win_ovf && !win_unf && !link_we, "R1 pulses", 64'({win_ovf, win_unf, link_we}), 0);
    // R1 mask cleared: save from window 0 wraps to NW-1 with no overflow
    @(negedge clk); save_req = 1; fire();
    chk(cur_win == NW - 1 && !win_ovf, "R1 mask zero", 64'(cur_win), NW - 1);
    exp_win = NW - 1;

    // R2 R3 R4 R5 sweep over every mask and start window
    for (int m = 0; m < 256; m++) begin
      for (int c = 0; c < NW; c++) begin
        load_mask('0);
        while (exp_win != c) begin
          @(negedge clk); restore_req = 1; fire();
          exp_win = wup(exp_win);
        end
        load_mask(NW'(m));
        begin
          int d;
          bit blk;
          d = wdn(c);
          blk = m[d];
          @(negedge clk); save_req = 1; fire();
          if (blk) begin
            chk(win_ovf == 1, "R3 ovf pulse", 64'(win_ovf), 1);
            chk(cur_win == c, "R3 win held", 64'(cur_win), 64'(c));
          end else begin
            chk(win_ovf == 0, "R2 no ovf", 64'(win_ovf), 0);
            chk(cur_win == d, "R2 win down", 64'(cur_win), 64'(d));
            exp_win = d;
          end
          chk(win_unf == 0, "R2 no unf", 64'(win_unf), 0);
          d = wup(exp_win);
          blk = m[d];
          @(negedge clk); restore_req = 1; fire();
          if (blk) begin
            chk(win_unf == 1, "R5 unf pulse", 64'(win_unf), 1);
            chk(cur_win == exp_win, "R5 win held", 64'(cur_win), 64'(exp_win));
          end else begin
            chk(win_unf == 0, "R4 no unf", 64'(win_unf), 0);
            chk(cur_win == d, "R4 win up", 64'(cur_win), 64'(d));
            exp_win = d;
          end
          chk(win_ovf == 0, "R4 no ovf", 64'(win_ovf), 0);
          @(negedge clk);
          chk(!win_ovf && !win_unf, "R3 one cycle pulse", 64'({win_ovf, win_unf}), 0);
        end
      end
    end

    // R9 save beats restore
    load_mask('0);
    @(negedge clk); save_req = 1; restore_req = 1; fire();
    chk(cur_win == wdn(exp_win), "R9 save over restore", 64'(cur_win), 64'(wdn(exp_win)));
    exp_win = wdn(exp_win);

    // R10 mask loaded in same cycle as save is not yet used
    @(negedge clk); wim_we = 1; wim_wdata = '1; save_req = 1; fire();
    chk(cur_win == wdn(exp_win) && !win_ovf, "R10 mask next cycle", 64'(cur_win), 64'(wdn(exp_win)));
    exp_win = wdn(exp_win);

    // R6 R7 R8 R9 R10 trap sweep, mask fully set
    for (int t = 0; t < 256; t++) begin
      logic [BWB-1:0] bv;
      logic [XL-1:0] p, np, e0, e1, et;
      bv = BWB'(t * 12345 + 7);
      @(negedge clk); ctl_we = 1; ctl_sup = t[0]; ctl_en = 1; base_we = 1; base_wdata = bv; fire();
      chk(sup == t[0] && trap_en == 1, "R10 ctl write", 64'({sup, trap_en}), 64'({t[0], 1'b1}));
      p = 32'h0000_4000 + XL'(t * 8);
      np = p + 4;
      @(negedge clk);
      trap_req = 1; trap_type = TW'(t); pc = p; npc = np;
      save_req = t[1]; restore_req = t[2];
      fire();
      chk(cur_win == wdn(exp_win), "R6 trap window", 64'(cur_win), 64'(wdn(exp_win)));
      chk(!win_ovf && !win_unf, "R9 trap wins", 64'({win_ovf, win_unf}), 0);
      chk(prev_sup == t[0] && sup == 1 && trap_en == 0, "R6 mode bits",
          64'({prev_sup, sup, trap_en}), 64'({t[0], 2'b10}));
      et = {bv, TW'(t), 4'b0000};
      chk(tbr == et, "R7 tbr", 64'(tbr), 64'(et));
      e0 = t[7] ? p : p - 4;
      e1 = t[7] ? np : p;
      chk(link_we == 1 && link_win == wdn(exp_win), "R8 link window",
          64'({link_we, link_win}), 64'({1'b1, CWB'(wdn(exp_win))}));
      chk(link_ret0 == e0 && link_ret1 == e1, "R8 link values",
          64'({link_ret0, link_ret1}), 64'({e0, e1}));
      exp_win = wdn(exp_win);
      @(negedge clk);
      chk(link_we == 0, "R8 one cycle strobe", 64'(link_we), 0);
    end

    // R10 ctl write ignored in a trap cycle
    @(negedge clk); ctl_we = 1; ctl_sup = 0; ctl_en = 1; fire();
    @(negedge clk); ctl_we = 1; ctl_sup = 0; ctl_en = 1; trap_req = 1; trap_type = 8'h11; fire();
    chk(sup == 1 && trap_en == 0 && prev_sup == 0, "R10 ctl vs trap",
        64'({sup, trap_en, prev_sup}), 64'(3'b100));

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule